// File: doc/BRIEF.md
# Dual-Buffer Frame Receiver with Destination Filter

This block is the receive half of a small Ethernet MAC. Frame bytes arrive one per cycle on a byte stream that marks the first and last byte of each frame. The block looks at the destination address and accepts the frame only if it is a group frame or if it is addressed to the station's own MAC address. It writes accepted frames, packed four bytes per word, into one of two receive buffers. Once a frame has been written, the block sets a full flag in that buffer's control word and can raise a one-cycle interrupt.

Software reads frame data and the control words over a simple word-addressed bus that spans an 8 KB window. The receive buffers sit in the upper half of this window. When software has consumed a buffer, it frees the buffer by clearing the full flag. With ping-pong mode enabled, the block switches to the other buffer after every accepted frame, so that one frame can be processed while the next one is arriving. With ping-pong mode disabled, all traffic goes to buffer 0. A frame that is aimed at a buffer which is still full is lost. The block has no received-length register, so software works from the frame contents.

Top module: `frame_rx_dualbuf`

## Requirements
- R1: Word address 0x400+k (byte 0x1000+4k) holds data word k of buffer 0 and 0x600+k holds word k of buffer 1, for k = 0..510. Word 0x5FF is the control word of buffer 0 and 0x7FF is the control word of buffer 1. A read of any word below 0x400 returns 0. `bus_rdata` is valid in the cycle after the cycle that asserts `bus_rd`.
- R2: A frame whose first byte has bit 7 set is accepted whatever its other address bytes are.
- R3: A frame whose first byte has bit 7 clear is accepted only when bytes 0..5 equal `mac_addr[47:40]` down to `mac_addr[7:0]`. Any other frame leaves both control words, `rx_ready` and `irq` unchanged.
- R4: A frame shorter than six bytes is never accepted.
- R5: A frame that starts while the full flag of its target buffer is set is dropped, and the data words of that buffer keep their contents.
- R6: The control word reads as bit 0 = full flag and bit 3 = interrupt enable, with all other bits 0. Accepting a frame sets the full flag of the buffer that received it.
- R7: Accepting a frame drives `irq` high for exactly one cycle, in the cycle after the last byte, only when that buffer's interrupt-enable bit and `irq_global_en` are both 1.
- R8: With `pingpong_en` = 1 the target buffer alternates 0, 1, 0, … after each accepted frame, starting from 0 after reset. With `pingpong_en` = 0 the target does not change.
- R9: `rx_ready` is 1 exactly when the full flag of buffer 0 is clear.
- R10: Frame byte n goes to word n/4, in bit lane 31..24 when n mod 4 = 0, 23..16 when it is 1, 15..8 when it is 2 and 7..0 when it is 3. Lanes of the last word that no frame byte reaches read 0.
- R11: Bytes at or beyond index 2044 are not stored. The control word is never overwritten by data, and a truncated frame is still accepted.
- R12: A bus write to a control word loads the full flag from bit 0 and the interrupt enable from bit 3. Writing 0 to bit 0 frees the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_sof | input | 1 | The byte is the first byte of a frame |
| rx_eof | input | 1 | The byte is the last byte of a frame |
| rx_data | input | 8 | Frame byte |
| mac_addr | input | 48 | Station address; bits 47:40 are compared with the first byte |
| pingpong_en | input | 1 | Alternate between the two buffers |
| irq_global_en | input | 1 | Master enable for the interrupt |
| bus_addr | input | 11 | Word address inside the 8 KB window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| rx_ready | output | 1 | Buffer 0 can take a frame |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Every accept decision is made on the clock edge that takes in the frame's last byte. The full flag and `rx_ready` therefore change at that edge, and `irq` is high during the cycle that follows it. The bench drives and samples on the falling edge. It reads `irq` through a pulse counter that also samples on the falling edge, and it compares that counter only after one idle cycle has passed after the frame. Register reads take one cycle. Each read task raises the strobe for one cycle and samples `bus_rdata` at the next falling edge, so every check of a flag or a data word happens after the edge that updated it.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
   localparam int NUM_BUFS   = 2;
   localparam int MAC_BYTES  = 6;
   localparam int FULL_BIT   = 0;
   localparam int IEN_BIT    = 3;

   function automatic logic [31:0] ctrl_image(input logic full, input logic ien);
      logic [31:0] w;
      w = '0;
      w[FULL_BIT] = full;
      w[IEN_BIT]  = ien;
      return w;
   endfunction
endpackage

// File: rtl/rxpp_addr_filter.sv
module rxpp_addr_filter #(
   parameter int MAC_BYTES = 6,
   parameter int IDX_W     = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   byte_en,
   input  logic                   first,
   input  logic [IDX_W-1:0]       byte_idx,
   input  logic [7:0]             data,
   input  logic [8*MAC_BYTES-1:0] mac,
   output logic                   pass_now,
   output logic                   long_enough
);
   logic [7:0] mac_b [MAC_BYTES];
   logic       grp_q, match_q;
   logic       grp_now, match_now, hit;

   for (genvar k = 0; k < MAC_BYTES; k++) begin : g_macb
      assign mac_b[k] = mac[8*(MAC_BYTES-1-k) +: 8];
   end

   always_comb begin
      hit = 1'b1;
      for (int k = 0; k < MAC_BYTES; k++) begin
         if (byte_idx == IDX_W'(k)) hit = (data == mac_b[k]);
      end
   end

   assign grp_now     = first ? data[7] : grp_q;
   assign match_now   = (first ? 1'b1 : match_q) && hit;
   assign pass_now    = grp_now || match_now;
   assign long_enough = byte_idx >= IDX_W'(MAC_BYTES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_q   <= 1'b0;
         match_q <= 1'b0;
      end else if (byte_en) begin
         grp_q   <= grp_now;
         match_q <= match_now;
      end
   end
endmodule

// File: rtl/rxpp_word_packer.sv
module rxpp_word_packer #(
   parameter int BUF_WORDS = 512,
   parameter int IDX_W     = 12,
   parameter int WA_W      = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_en,
   input  logic             first,
   input  logic             discard,
   input  logic [7:0]       data,
   output logic [IDX_W-1:0] byte_idx,
   output logic             wr_en,
   output logic [WA_W-1:0]  wr_addr,
   output logic [31:0]      wr_data
);
   localparam int DATA_WORDS = BUF_WORDS - 1;
   localparam logic [IDX_W-1:0] IDX_MAX = '1;

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-3:0] word_idx;
   logic [1:0]       lane;
   logic [31:0]      word_q, placed;

   assign byte_idx = first ? '0 : idx_q;
   assign word_idx = byte_idx[IDX_W-1:2];
   assign lane     = byte_idx[1:0];
   assign placed   = {data, 24'h0} >> {lane, 3'b000};
   assign wr_data  = (lane == 2'd0) ? placed : (word_q | placed);
   assign wr_addr  = word_idx[WA_W-1:0];
   assign wr_en    = byte_en && !discard && (word_idx < (IDX_W-2)'(DATA_WORDS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         word_q <= '0;
      end else if (byte_en) begin
         idx_q  <= (byte_idx == IDX_MAX) ? byte_idx : byte_idx + 1'b1;
         word_q <= wr_data;
      end
   end
endmodule

// File: rtl/rxpp_buf_bank.sv
module rxpp_buf_bank #(
   parameter int BUF_WORDS = 512,
   parameter int WA_W      = 9
) (
   input  logic            clk,
   input  logic            we,
   input  logic [WA_W-1:0] waddr,
   input  logic [31:0]     wdata,
   input  logic            re,
   input  logic [WA_W-1:0] raddr,
   output logic [31:0]     rdata
);
   logic [31:0] mem [BUF_WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/rxpp_ctrl_regs.sv
module rxpp_ctrl_regs
   import rxpp_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sof_byte,
   input  logic                eof_byte,
   input  logic                verdict,
   input  logic [NUM_BUFS-1:0] cpu_wr,
   input  logic                cpu_full,
   input  logic                cpu_ien,
   input  logic                gie,
   input  logic                pp_en,
   output logic [NUM_BUFS-1:0] full_q,
   output logic [NUM_BUFS-1:0] ien_q,
   output logic                tgt_cur,
   output logic                discard,
   output logic                act_q,
   output logic                irq_q
);
   logic tgt_q, drop_q, accept;

   assign tgt_cur = sof_byte ? act_q : tgt_q;
   assign discard = sof_byte ? full_q[act_q] : drop_q;
   assign accept  = eof_byte && !discard && verdict;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q  <= 1'b0;
         drop_q <= 1'b0;
         act_q  <= 1'b0;
         irq_q  <= 1'b0;
         full_q <= '0;
         ien_q  <= '0;
      end else begin
         if (sof_byte) begin
            tgt_q  <= act_q;
            drop_q <= full_q[act_q];
         end
         for (int b = 0; b < NUM_BUFS; b++) begin
            if (cpu_wr[b]) begin
               full_q[b] <= cpu_full;
               ien_q[b]  <= cpu_ien;
            end
            if (accept && (tgt_cur == 1'(b))) full_q[b] <= 1'b1;
         end
         irq_q <= accept && ien_q[tgt_cur] && gie;
         if (accept) act_q <= act_q ^ pp_en;
      end
   end
endmodule

// File: rtl/frame_rx_dualbuf.sv
module frame_rx_dualbuf
   import rxpp_pkg::*;
#(
   parameter int BUF_WORDS = 512,
   parameter int ADDR_W    = $clog2(4 * BUF_WORDS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rx_valid,
   input  logic                   rx_sof,
   input  logic                   rx_eof,
   input  logic [7:0]             rx_data,
   input  logic [8*MAC_BYTES-1:0] mac_addr,
   input  logic                   pingpong_en,
   input  logic                   irq_global_en,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic                   bus_wr,
   input  logic [31:0]            bus_wdata,
   input  logic                   bus_rd,
   output logic [31:0]            bus_rdata,
   output logic                   rx_ready,
   output logic                   irq
);
   localparam int WA_W  = $clog2(BUF_WORDS);
   localparam int IDX_W = WA_W + 3;
   localparam logic [WA_W-1:0] CTRL_OFS = WA_W'(BUF_WORDS - 1);

   if (BUF_WORDS < 4 || (BUF_WORDS & (BUF_WORDS - 1)) != 0) begin : g_bad_depth
      $error("BUF_WORDS must be a power of two and at least 4");
   end
   if (ADDR_W != WA_W + 2) begin : g_bad_addr
      $error("ADDR_W must cover four buffer-sized regions");
   end

   logic in_frame_q, byte_en, sof_byte, eof_byte;
   logic [IDX_W-1:0] byte_idx;
   logic pass_now, long_enough;
   logic pk_we, discard, drop_now, tgt_cur, act_q;
   logic [WA_W-1:0] pk_addr;
   logic [31:0] pk_data;
   logic [NUM_BUFS-1:0] full_q, ien_q, cpu_wr, bank_re;
   logic in_rx, is_ctrl, buf_sel;
   logic [WA_W-1:0] ofs;
   logic [31:0] bank_rdata [NUM_BUFS];
   logic rd_ctrl_q, rd_data_q, rd_buf_q;
   logic [31:0] ctrl_snap_q;
   logic unused_wbits;

   assign unused_wbits = ^{bus_wdata[31:4], bus_wdata[2:1]};

   // Frame framing
   assign byte_en  = rx_valid && (rx_sof || in_frame_q);
   assign sof_byte = rx_valid && rx_sof;
   assign eof_byte = byte_en && rx_eof;
   assign drop_now = byte_en && discard;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) in_frame_q <= 1'b0;
      else if (byte_en) in_frame_q <= !rx_eof;
   end

   rxpp_addr_filter #(.MAC_BYTES(MAC_BYTES), .IDX_W(IDX_W)) u_filter (
      .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .first(sof_byte),
      .byte_idx(byte_idx), .data(rx_data), .mac(mac_addr),
      .pass_now(pass_now), .long_enough(long_enough)
   );

   rxpp_word_packer #(.BUF_WORDS(BUF_WORDS), .IDX_W(IDX_W), .WA_W(WA_W)) u_packer (
      .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .first(sof_byte),
      .discard(discard), .data(rx_data), .byte_idx(byte_idx),
      .wr_en(pk_we), .wr_addr(pk_addr), .wr_data(pk_data)
   );

   rxpp_ctrl_regs u_ctrl (
      .clk(clk), .rst_n(rst_n), .sof_byte(sof_byte), .eof_byte(eof_byte),
      .verdict(pass_now && long_enough), .cpu_wr(cpu_wr),
      .cpu_full(bus_wdata[FULL_BIT]), .cpu_ien(bus_wdata[IEN_BIT]),
      .gie(irq_global_en), .pp_en(pingpong_en), .full_q(full_q), .ien_q(ien_q),
      .tgt_cur(tgt_cur), .discard(discard), .act_q(act_q), .irq_q(irq)
   );

   // Bus decode
   assign in_rx   = bus_addr[ADDR_W-1];
   assign buf_sel = bus_addr[ADDR_W-2];
   assign ofs     = bus_addr[WA_W-1:0];
   assign is_ctrl = (ofs == CTRL_OFS);

   for (genvar b = 0; b < NUM_BUFS; b++) begin : g_bank
      assign cpu_wr[b]  = bus_wr && in_rx && is_ctrl && (buf_sel == 1'(b));
      assign bank_re[b] = bus_rd && in_rx && !is_ctrl && (buf_sel == 1'(b));
      rxpp_buf_bank #(.BUF_WORDS(BUF_WORDS), .WA_W(WA_W)) u_bank (
         .clk(clk), .we(pk_we && (tgt_cur == 1'(b))), .waddr(pk_addr),
         .wdata(pk_data), .re(bank_re[b]), .raddr(ofs), .rdata(bank_rdata[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ctrl_q   <= 1'b0;
         rd_data_q   <= 1'b0;
         rd_buf_q    <= 1'b0;
         ctrl_snap_q <= '0;
      end else if (bus_rd) begin
         rd_ctrl_q   <= in_rx && is_ctrl;
         rd_data_q   <= in_rx && !is_ctrl;
         rd_buf_q    <= buf_sel;
         ctrl_snap_q <= ctrl_image(full_q[buf_sel], ien_q[buf_sel]);
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_ctrl_q) bus_rdata = ctrl_snap_q;
      else if (rd_data_q) bus_rdata = bank_rdata[rd_buf_q];
   end

   assign rx_ready = !full_q[0];
endmodule

// File: rtl/frame_rx_dualbuf_chk.sv
module frame_rx_dualbuf_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_valid,
   input logic rx_eof,
   input logic rx_ready,
   input logic irq,
   input logic irq_global_en,
   input logic pingpong_en,
   input logic bus_wr,
   input logic act,
   input logic frame_drop,
   input logic word_we
);
   // R7: a single-cycle pulse
   p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R7: only after a last byte with the global enable set
   p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(irq_global_en) && $past(rx_valid && rx_eof)));

   // R9: buffer 0 becomes busy only by a frame end or a bus write
   p_ready_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_ready) |-> ($past(rx_valid && rx_eof) || $past(bus_wr)));

   // R5: a dropped frame never writes the buffer
   p_no_write_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_drop |-> !word_we);

   // R8: the target holds while alternation is off
   p_target_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pingpong_en |=> $stable(act));
endmodule

bind frame_rx_dualbuf frame_rx_dualbuf_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eof(rx_eof),
   .rx_ready(rx_ready), .irq(irq), .irq_global_en(irq_global_en),
   .pingpong_en(pingpong_en), .bus_wr(bus_wr), .act(act_q),
   .frame_drop(drop_now), .word_we(pk_we)
);

// File: tb/frame_rx_dualbuf_bench.sv
module frame_rx_dualbuf_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
   logic [7:0]  rx_data = '0;
   logic [47:0] mac_addr = 48'h02005E102030;
   logic        pingpong_en = 1'b0, irq_global_en = 1'b1;
   logic [10:0] bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_ready, irq;

   int vectors = 0, fails = 0, irq_cnt = 0;
   logic [7:0] fb [0:2199];

   always #2 clk = ~clk;

   frame_rx_dualbuf u_frame_rx_dualbuf (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
      .rx_eof(rx_eof), .rx_data(rx_data), .mac_addr(mac_addr),
      .pingpong_en(pingpong_en), .irq_global_en(irq_global_en),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_rdata(bus_rdata), .rx_ready(rx_ready), .irq(irq)
   );

   always @(negedge clk) if (rst_n && irq) irq_cnt++;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [10:0] a, output logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
   endtask

   task automatic wr(input logic [10:0] a, input logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic build(input logic [47:0] dst, input logic [7:0] seed, input int len);
      for (int i = 0; i < len; i++)
         fb[i] = (i < 6) ? dst[8*(5-i) +: 8] : 8'(seed + 8'(i - 6));
   endtask

   task automatic send(input int len);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = fb[i];
         rx_sof = (i == 0); rx_eof = (i == len - 1);
      end
      @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R9 ready after reset", 32'(rx_ready), 32'd1);
      check("R7 irq idle after reset", 32'(irq), 32'd0);
      rd(11'h5FF, d); check("R6 ctrl0 after reset", d, 32'h0);
      rd(11'h7FF, d); check("R6 ctrl1 after reset", d, 32'h0);
   endtask

   task automatic t_group();
      logic [31:0] d; int c0;
      wr(11'h5FF, 32'h8);
      c0 = irq_cnt;
      build(48'hFF0102030405, 8'hA0, 10); send(10);
      check("R7 irq pulse once", 32'(irq_cnt - c0), 32'd1);
      check("R9 ready low when full", 32'(rx_ready), 32'd0);
      rd(11'h5FF, d); check("R6 ctrl0 full+ien", d, 32'h9);
      rd(11'h7FF, d); check("R8 buffer1 unused with alternation off", d, 32'h0);
      rd(11'h400, d); check("R2 R10 word0", d, 32'hFF010203);
      rd(11'h401, d); check("R10 word1", d, 32'h0405A0A1);
      rd(11'h402, d); check("R10 padded tail", d, 32'hA2A30000);
      rd(11'h010, d); check("R1 outside window reads 0", d, 32'h0);
   endtask

   task automatic t_full();
      logic [31:0] d; int c0;
      c0 = irq_cnt;
      build(48'hF0AABBCCDDEE, 8'h55, 12); send(12);
      check("R5 no irq on dropped frame", 32'(irq_cnt - c0), 32'd0);
      rd(11'h400, d); check("R5 word0 kept", d, 32'hFF010203);
      rd(11'h402, d); check("R5 word2 kept", d, 32'hA2A30000);
      wr(11'h5FF, 32'h0);
      check("R12 R9 ready after clear", 32'(rx_ready), 32'd1);
      rd(11'h5FF, d); check("R12 ctrl0 cleared", d, 32'h0);
   endtask

   task automatic t_unicast();
      logic [31:0] d; int c0;
      c0 = irq_cnt;
      build(48'h02005E102031, 8'h30, 9); send(9);
      rd(11'h5FF, d); check("R3 mismatch not accepted", d, 32'h0);
      check("R3 ready unchanged", 32'(rx_ready), 32'd1);
      build(48'h02005E102030, 8'h40, 9); send(9);
      rd(11'h5FF, d); check("R3 exact match accepted", d, 32'h1);
      rd(11'h401, d); check("R3 R10 matched data", d, 32'h20304041);
      check("R7 no irq with ien clear", 32'(irq_cnt - c0), 32'd0);
      wr(11'h5FF, 32'h0);
   endtask

   task automatic t_short();
      logic [31:0] d;
      build(48'hFFFFFFFFFFFF, 8'h0, 5); send(5);
      rd(11'h5FF, d); check("R4 five-byte frame rejected", d, 32'h0);
   endtask

   task automatic t_gie_off();
      logic [31:0] d; int c0;
      irq_global_en = 1'b0;
      wr(11'h5FF, 32'h8);
      c0 = irq_cnt;
      build(48'h810000000000, 8'h0, 8); send(8);
      check("R7 no irq with global enable off", 32'(irq_cnt - c0), 32'd0);
      rd(11'h5FF, d); check("R6 full set without irq", d, 32'h9);
      wr(11'h5FF, 32'h0);
      irq_global_en = 1'b1;
   endtask

   task automatic t_pingpong();
      logic [31:0] d;
      pingpong_en = 1'b1;
      build(48'hFF0102030405, 8'h10, 8); send(8);
      build(48'hFF0102030405, 8'h20, 8); send(8);
      rd(11'h5FF, d); check("R8 first frame to buffer0", d, 32'h1);
      rd(11'h7FF, d); check("R8 second frame to buffer1", d, 32'h1);
      rd(11'h401, d); check("R8 buffer0 data", d, 32'h04051011);
      rd(11'h601, d); check("R1 R8 buffer1 data", d, 32'h04052021);
      wr(11'h5FF, 32'h0); wr(11'h7FF, 32'h0);
      pingpong_en = 1'b0;
   endtask

   task automatic t_trunc();
      logic [31:0] d;
      for (int i = 0; i < 2050; i++) fb[i] = 8'(i + 128);
      send(2050);
      rd(11'h5FF, d); check("R11 truncated frame accepted", d, 32'h1);
      rd(11'h400, d); check("R11 word0", d, 32'h80818283);
      rd(11'h5FE, d); check("R11 last data word", d, 32'h78797A7B);
      wr(11'h5FF, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_group();
      t_full();
      t_unicast();
      t_short();
      t_gie_off();
      t_pingpong();
      t_trunc();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule